// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is an in-order integer core with five pipeline stages: fetch, decode with register read, execute, memory access and write-back. It runs a small 32-bit instruction subset made of four register-to-register operations (add, subtract, and, or), a word load, a word store and a branch taken when two registers are equal. Instruction memory and data memory sit outside the block on separate ports. Both are read combinationally from the address the core presents, and the data memory is written on the clock edge while the store enable is high.

Each pipeline register holds a valid bit and its own copy of the instruction word, and every stage decodes the control it needs from that copy. All instruction classes write the register file in the fifth stage only, so the single write port is never asked for twice in one cycle. Operand hazards are handled in three ways. Results are forwarded into the execute stage. The register file passes a value written in a cycle to a read of the same register in that cycle. A consumer that directly follows a load is held back for one cycle. A taken branch discards the two younger instructions already in flight.

Top module: `pipe5_core`

## Requirements
- R1: After reset the core fetches from address 0. With no stall or taken branch, one instruction is fetched per cycle at the previous address plus 4, and an instruction fetched in cycle k reaches the memory stage in cycle k+3.
- R2: Register results from the register operations and from loads are written to the register file only from the fifth stage, one cycle after the instruction leaves the memory stage.
- R3: A store writes data memory (address rs + offset, data rt) during its memory stage and changes no register.
- R4: A branch (opcode 4) compares rs and rt in execute. When they are equal, the next fetch address is the branch's own address + 4 + (sign-extended offset × 4). Otherwise fetch continues in sequence.
- R5: A register written in a given cycle is seen by a decode-stage read of that register in the same cycle.
- R6: A result held in the execute/memory or memory/write-back pipeline register is forwarded to a dependent instruction in execute. The younger producer has priority, so the program never notices the distance between producer and consumer.
- R7: An instruction that reads the destination of the load directly ahead of it is delayed by exactly one cycle, and it still obtains the loaded value.
- R8: During that delay the fetch address and the decode-stage instruction hold, and an invalid bubble enters execute.
- R9: A taken branch cancels the two instructions fetched after it, and neither of them writes memory or registers.
- R10: Register 0 always reads as zero. Writes to it are dropped, and nothing is forwarded from them.
- R11: Instruction format: opcode [31:26] (0 no-op, 1 register operation, 2 load, 3 store, 4 branch-if-equal), rs [25:21], rt [20:16], rd [15:11], operation select [1:0] (0 add, 1 subtract, 2 and, 3 or), signed offset [15:0]. A register operation writes rd and a load writes rt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Byte address for the memory-stage access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store enable, data memory written on the clock edge |
| dmem_rdata | input | 32 | Load data at dmem_addr |

## Verification
The bound checker watches pipeline sequencing on every cycle. It checks that the fetch address advances by 4, that the stage contents and fetch address hold during a load-use delay while a bubble enters execute, and that a taken branch redirects fetch and clears both younger slots. It also checks that a register operation in the memory stage is written back the following cycle, that stores never write a register, and that register 0 is never a write target. Whether the correct values flow through the forwarding paths, the same-cycle register bypass and the data memory can only be shown by the bench's programs. These sweep every operation against every producer-to-consumer distance, compare branch operands that are equal or differ in a single bit, and time the memory writes that follow a stall or a squash.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int XLEN   = 32;
    localparam int ILEN   = 32;
    localparam int RIDX   = 5;
    localparam int IMMW   = 16;
    localparam int IBYTES = ILEN / 8;

    localparam logic [5:0] OPC_NOP = 6'd0;
    localparam logic [5:0] OPC_ALU = 6'd1;
    localparam logic [5:0] OPC_LD  = 6'd2;
    localparam logic [5:0] OPC_ST  = 6'd3;
    localparam logic [5:0] OPC_BEQ = 6'd4;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_OR  = 2'd3
    } alu_fn_e;

    typedef enum logic [1:0] {
        SRC_FILE  = 2'd0,
        SRC_EXMEM = 2'd1,
        SRC_MEMWB = 2'd2
    } fwd_sel_e;

    typedef struct packed {
        logic            wr_reg;
        logic [RIDX-1:0] dst;
        logic            use_rs;
        logic            use_rt;
        logic            is_ld;
        logic            is_st;
        logic            is_br;
        logic            imm_b;
        alu_fn_e         fn;
    } ctrl_t;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] pc;
        logic [ILEN-1:0] ir;
        logic [XLEN-1:0] opa;
        logic [XLEN-1:0] opb;
        logic [XLEN-1:0] res;
    } stage_t;

    function automatic logic [RIDX-1:0] f_rs(input logic [ILEN-1:0] ir);
        return ir[25:21];
    endfunction

    function automatic logic [RIDX-1:0] f_rt(input logic [ILEN-1:0] ir);
        return ir[20:16];
    endfunction

    function automatic logic [RIDX-1:0] f_rd(input logic [ILEN-1:0] ir);
        return ir[15:11];
    endfunction

    function automatic logic [XLEN-1:0] f_imm(input logic [ILEN-1:0] ir);
        return {{(XLEN-IMMW){ir[IMMW-1]}}, ir[IMMW-1:0]};
    endfunction

    // Per-stage control decode from the instruction copy the stage holds.
    function automatic ctrl_t decode_f(input logic [ILEN-1:0] ir);
        ctrl_t c;
        c = '0;
        case (ir[31:26])
            OPC_ALU: begin
                c.wr_reg = 1'b1;
                c.dst    = f_rd(ir);
                c.use_rs = 1'b1;
                c.use_rt = 1'b1;
                c.fn     = alu_fn_e'(ir[1:0]);
            end
            OPC_LD: begin
                c.wr_reg = 1'b1;
                c.dst    = f_rt(ir);
                c.use_rs = 1'b1;
                c.is_ld  = 1'b1;
                c.imm_b  = 1'b1;
            end
            OPC_ST: begin
                c.use_rs = 1'b1;
                c.use_rt = 1'b1;
                c.is_st  = 1'b1;
                c.imm_b  = 1'b1;
            end
            OPC_BEQ: begin
                c.use_rs = 1'b1;
                c.use_rt = 1'b1;
                c.is_br  = 1'b1;
            end
            default: ;
        endcase
        // Register 0 is never a destination.
        if (c.dst == '0) c.wr_reg = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
    import pipe5_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int AW = RIDX,
    parameter int NR = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NR-1:0][AW-1:0] raddr,
    output logic [NR-1:0][W-1:0]  rdata,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [W-1:0]         wdata
);
    localparam int NENT = 1 << AW;

    logic [W-1:0] mem_q [NENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NENT; i++) mem_q[i] <= '0;
        end else if (we && waddr != '0) begin
            mem_q[waddr] <= wdata;
        end
    end

    generate
        for (genvar p = 0; p < NR; p++) begin : g_rd
            always_comb begin
                if (raddr[p] == '0)
                    rdata[p] = '0;
                else if (we && waddr == raddr[p])
                    rdata[p] = wdata;
                else
                    rdata[p] = mem_q[raddr[p]];
            end
        end
    endgenerate

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
    import pipe5_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_fn_e      fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        case (fn)
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            default: y = a | b;
        endcase
    end
endmodule

// File: rtl/pipe5_hazard.sv
module pipe5_hazard
    import pipe5_pkg::*;
(
    input  logic            fd_valid,
    input  logic [ILEN-1:0] fd_ir,
    input  logic            de_valid,
    input  logic [ILEN-1:0] de_ir,
    input  logic            em_valid,
    input  logic [ILEN-1:0] em_ir,
    input  logic            mw_valid,
    input  logic [ILEN-1:0] mw_ir,
    output logic            stall,
    output fwd_sel_e        sel_a,
    output fwd_sel_e        sel_b
);
    ctrl_t c_id, c_ex, c_mem, c_wb;

    assign c_id  = decode_f(fd_ir);
    assign c_ex  = decode_f(de_ir);
    assign c_mem = decode_f(em_ir);
    assign c_wb  = decode_f(mw_ir);

    function automatic fwd_sel_e pick(input logic [RIDX-1:0] r);
        if (em_valid && c_mem.wr_reg && !c_mem.is_ld && c_mem.dst == r)
            return SRC_EXMEM;
        else if (mw_valid && c_wb.wr_reg && c_wb.dst == r)
            return SRC_MEMWB;
        else
            return SRC_FILE;
    endfunction

    assign sel_a = pick(f_rs(de_ir));
    assign sel_b = pick(f_rt(de_ir));

    logic hit_rs, hit_rt;
    assign hit_rs = c_id.use_rs && f_rs(fd_ir) == c_ex.dst;
    assign hit_rt = c_id.use_rt && f_rt(fd_ir) == c_ex.dst;
    assign stall  = de_valid && c_ex.is_ld && c_ex.wr_reg && fd_valid && (hit_rs || hit_rt);

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [ILEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);
    localparam logic [XLEN-1:0] STEP = XLEN'(IBYTES);

    logic [XLEN-1:0] pc_q;
    stage_t fd_q, de_q, em_q, mw_q;
    stage_t de_nxt, em_nxt, mw_nxt;
    ctrl_t  ce, cm, cw;

    // ---------------- fetch ----------------
    assign imem_addr = pc_q;

    // ---------------- decode / register read ----------------
    logic [1:0][RIDX-1:0] rf_raddr;
    logic [1:0][XLEN-1:0] rf_rdata;
    logic                 rf_we;
    logic [RIDX-1:0]      rf_waddr;
    logic [XLEN-1:0]      rf_wdata;

    assign rf_raddr[0] = f_rs(fd_q.ir);
    assign rf_raddr[1] = f_rt(fd_q.ir);

    pipe5_regfile #(.W(XLEN), .AW(RIDX), .NR(2)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .raddr (rf_raddr),
        .rdata (rf_rdata),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata)
    );

    logic     stall;
    fwd_sel_e sel_a, sel_b;

    pipe5_hazard u_hz (
        .fd_valid (fd_q.valid),
        .fd_ir    (fd_q.ir),
        .de_valid (de_q.valid),
        .de_ir    (de_q.ir),
        .em_valid (em_q.valid),
        .em_ir    (em_q.ir),
        .mw_valid (mw_q.valid),
        .mw_ir    (mw_q.ir),
        .stall    (stall),
        .sel_a    (sel_a),
        .sel_b    (sel_b)
    );

    always_comb begin
        de_nxt       = '0;
        de_nxt.valid = fd_q.valid;
        de_nxt.pc    = fd_q.pc;
        de_nxt.ir    = fd_q.ir;
        de_nxt.opa   = rf_rdata[0];
        de_nxt.opb   = rf_rdata[1];
    end

    // ---------------- execute ----------------
    logic [XLEN-1:0] a_fw, b_fw, alu_b, ex_res, br_target;
    logic            br_taken;

    assign ce = decode_f(de_q.ir);

    always_comb begin
        case (sel_a)
            SRC_EXMEM: a_fw = em_q.res;
            SRC_MEMWB: a_fw = mw_q.res;
            default:   a_fw = de_q.opa;
        endcase
        case (sel_b)
            SRC_EXMEM: b_fw = em_q.res;
            SRC_MEMWB: b_fw = mw_q.res;
            default:   b_fw = de_q.opb;
        endcase
    end

    assign alu_b = ce.imm_b ? f_imm(de_q.ir) : b_fw;

    pipe5_alu #(.W(XLEN)) u_alu (
        .fn (ce.fn),
        .a  (a_fw),
        .b  (alu_b),
        .y  (ex_res)
    );

    // Separate target adder beside the ALU.
    assign br_target = de_q.pc + STEP + (f_imm(de_q.ir) << 2);
    assign br_taken  = de_q.valid && ce.is_br && (a_fw == b_fw);

    always_comb begin
        em_nxt     = de_q;
        em_nxt.opa = a_fw;
        em_nxt.opb = b_fw;
        em_nxt.res = ex_res;
    end

    // ---------------- memory ----------------
    assign cm         = decode_f(em_q.ir);
    assign dmem_addr  = em_q.res;
    assign dmem_wdata = em_q.opb;
    assign dmem_we    = em_q.valid && cm.is_st;

    always_comb begin
        mw_nxt     = em_q;
        mw_nxt.res = cm.is_ld ? dmem_rdata : em_q.res;
    end

    // ---------------- write-back ----------------
    assign cw       = decode_f(mw_q.ir);
    assign rf_we    = mw_q.valid && cw.wr_reg;
    assign rf_waddr = cw.dst;
    assign rf_wdata = mw_q.res;

    // ---------------- sequencing ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC;
            fd_q <= '0;
            de_q <= '0;
            em_q <= '0;
            mw_q <= '0;
        end else begin
            mw_q <= mw_nxt;
            em_q <= em_nxt;
            if (br_taken) begin
                pc_q <= br_target;
                fd_q <= '0;
                de_q <= '0;
            end else if (stall) begin
                de_q <= '0;
            end else begin
                pc_q     <= pc_q + STEP;
                fd_q     <= '0;
                fd_q.valid <= 1'b1;
                fd_q.pc  <= pc_q;
                fd_q.ir  <= imem_rdata;
                de_q     <= de_nxt;
            end
        end
    end

endmodule

// File: rtl/pipe5_chk.sv
module pipe5_chk
    import pipe5_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc_q,
    input logic            fd_valid,
    input logic [ILEN-1:0] fd_ir,
    input logic            de_valid,
    input logic            em_valid,
    input logic [ILEN-1:0] em_ir,
    input logic            stall,
    input logic            br_taken,
    input logic [XLEN-1:0] br_target,
    input logic            dmem_we,
    input logic            rf_we,
    input logic [RIDX-1:0] rf_waddr
);
    assert_seq_fetch_R1: assert property (@(posedge clk) disable iff (rst)
        (!stall && !br_taken) |=> pc_q == $past(pc_q) + XLEN'(IBYTES));

    assert_wb_stage5_R2: assert property (@(posedge clk) disable iff (rst)
        (em_valid && em_ir[31:26] == OPC_ALU && em_ir[15:11] != '0)
        |=> (rf_we && rf_waddr == $past(em_ir[15:11])));

    assert_store_no_regwrite_R3: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> !rf_we);

    assert_branch_redirect_R4: assert property (@(posedge clk) disable iff (rst)
        br_taken |=> pc_q == $past(br_target));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        stall |=> (pc_q == $past(pc_q) && fd_ir == $past(fd_ir) && fd_valid && !de_valid));

    assert_branch_squash_R9: assert property (@(posedge clk) disable iff (rst)
        br_taken |=> (!fd_valid && !de_valid));

    assert_no_r0_write_R10: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> rf_waddr != '0);

endmodule

bind pipe5_core pipe5_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pc_q      (pc_q),
    .fd_valid  (fd_q.valid),
    .fd_ir     (fd_q.ir),
    .de_valid  (de_q.valid),
    .em_valid  (em_q.valid),
    .em_ir     (em_q.ir),
    .stall     (stall),
    .br_taken  (br_taken),
    .br_target (br_target),
    .dmem_we   (dmem_we),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr)
);

// File: tb/pipe5_core_tb.sv
module pipe5_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MEMW = 64;
    localparam logic [31:0] MARK = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [MEMW];
    logic [31:0] dmem [MEMW];
    int          wcyc [MEMW];
    int          cyc;
    int          total = 0;
    int          bad = 0;
    int          pk;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe5_core u_dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (rst) begin
            cyc <= 0;
        end else begin
            if (dmem_we) begin
                dmem[dmem_addr[7:2]] <= dmem_wdata;
                wcyc[dmem_addr[7:2]] <= cyc;
            end
            cyc <= cyc + 1;
        end
    end

    // ---------- encoders (field layout per R11) ----------
    function automatic logic [31:0] e_alu(input int fn, input int rd, input int rs, input int rt);
        return {6'd1, 5'(rs), 5'(rt), 5'(rd), 9'd0, 2'(fn)};
    endfunction
    function automatic logic [31:0] e_ld(input int rt, input int rs, input int off);
        return {6'd2, 5'(rs), 5'(rt), 16'(off)};
    endfunction
    function automatic logic [31:0] e_st(input int rt, input int rs, input int off);
        return {6'd3, 5'(rs), 5'(rt), 16'(off)};
    endfunction
    function automatic logic [31:0] e_beq(input int rs, input int rt, input int off);
        return {6'd4, 5'(rs), 5'(rt), 16'(off)};
    endfunction
    function automatic logic [31:0] model(input int fn, input logic [31:0] a, input logic [31:0] b);
        case (fn)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            default: return a | b;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] w);
        imem[pk] = w;
        pk++;
    endtask

    task automatic fresh();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < MEMW; i++) begin
            imem[i] = '0;
            dmem[i] = MARK;
            wcyc[i] = -1;
        end
        pk = 0;
    endtask

    task automatic run(input int n);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b, e;

        // Reset state (R1)
        fresh();
        repeat (2) @(negedge clk);
        chk("R1 reset fetch address", imem_addr, 32'd0);
        chk("R1 reset no store", {31'd0, dmem_we}, 32'd0);

        // Sweep: every operation x every producer/consumer distance (R2 R5 R6 R11)
        for (int fn = 0; fn < 4; fn++) begin
            for (int gap = 0; gap < 4; gap++) begin
                fresh();
                a = 32'h9ABC_0123 + 32'h0101_0101 * fn + gap;
                b = 32'h1357_9BDF ^ (32'h0000_0F00 << gap);
                dmem[0] = a;
                dmem[1] = b;
                put(e_ld(1, 0, 0));
                put(e_ld(2, 0, 4));
                put(0);
                put(0);
                put(e_alu(fn, 3, 1, 2));
                for (int g = 0; g < gap; g++) put(0);
                put(e_alu(0, 4, 3, 1));
                put(e_st(4, 0, 12));
                put(e_st(3, 0, 8));
                run(30);
                e = model(fn, a, b);
                chk("R11 operation result", dmem[2], e);
                if (gap < 2)
                    chk("R6 forwarded operand", dmem[3], e + a);
                else if (gap == 2)
                    chk("R5 R2 same-cycle register read", dmem[3], e + a);
                else
                    chk("R2 register file value", dmem[3], e + a);
            end
        end

        // Load-use delay (R7 R8)
        fresh();
        a = 32'h0000_7A31;
        dmem[0] = a;
        put(e_ld(1, 0, 0));
        put(e_alu(0, 2, 1, 1));
        put(e_st(2, 0, 8));
        run(25);
        chk("R7 load-use value", dmem[2], a + a);
        chk("R8 one-cycle hold timing", 32'(wcyc[2]), 32'd6);

        // Same distance plus one gap: no hold (R6 R7)
        fresh();
        dmem[0] = a;
        put(e_ld(1, 0, 0));
        put(0);
        put(e_alu(1, 2, 1, 0));
        put(e_st(2, 0, 8));
        run(25);
        chk("R6 load forwarded from write-back", dmem[2], a);
        chk("R7 no hold without adjacency", 32'(wcyc[2]), 32'd6);

        // Throughput and stores leave registers alone (R1 R3)
        fresh();
        a = 32'h1111_2222;
        b = 32'h3333_4444;
        dmem[0] = a;
        dmem[1] = b;
        put(e_ld(1, 0, 0));
        put(e_ld(2, 0, 4));
        put(0);
        put(0);
        put(e_st(1, 0, 16));
        put(e_st(2, 0, 20));
        put(e_st(1, 0, 24));
        put(e_st(2, 0, 28));
        put(0);
        put(0);
        put(0);
        put(e_st(1, 1, 32 - 32'h1111_2222 + 0));
        put(e_st(2, 0, 36));
        run(30);
        for (int s = 0; s < 4; s++) begin
            chk("R1 back-to-back memory stage cycle", 32'(wcyc[4+s]), 32'(7 + s));
            chk("R3 store data", dmem[4+s], (s % 2 == 0) ? a : b);
        end
        chk("R3 store kept rt register", dmem[9], b);

        // Branch on equal / unequal operands (R4 R9)
        for (int t = 0; t < 4; t++) begin
            fresh();
            case (t)
                0: begin a = 32'h5A5A_0F0F; b = a; end
                1: begin a = 32'h5A5A_0F0F; b = a ^ 32'h1; end
                2: begin a = 32'h0000_0040; b = a ^ 32'h8000_0000; end
                default: begin a = 32'h0; b = 32'h0; end
            endcase
            dmem[0] = a;
            dmem[1] = b;
            put(e_ld(1, 0, 0));
            put(e_ld(2, 0, 4));
            put(0);
            put(e_beq(1, 2, 2));
            put(e_st(1, 0, 16));
            put(e_st(1, 0, 20));
            put(e_st(2, 0, 24));
            run(25);
            e = (a == b) ? MARK : a;
            chk("R9 first younger slot", dmem[4], e);
            chk("R9 second younger slot", dmem[5], e);
            chk("R4 target store", dmem[6], b);
            chk("R4 target timing", 32'(wcyc[6]), 32'd9);
        end

        // Register 0 (R10)
        fresh();
        a = 32'h0BAD_F00D;
        dmem[0] = a;
        put(e_ld(1, 0, 0));
        put(0);
        put(0);
        put(e_alu(0, 0, 1, 1));
        put(e_st(0, 0, 28));
        put(0);
        put(0);
        put(0);
        put(e_st(0, 0, 32));
        put(e_ld(0, 0, 0));
        put(0);
        put(e_st(0, 0, 36));
        run(30);
        chk("R10 no forward from r0 write", dmem[7], 32'd0);
        chk("R10 r0 reads zero after op", dmem[8], 32'd0);
        chk("R10 r0 reads zero after load", dmem[9], 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule